// File: doc/BRIEF.md
# Dual-Direction Storing Bus Transceiver

This block moves a data word between two buses, side A and side B, through two independent non-inverting paths. Each path has one storage element whose mode depends on its mode-select input. With mode-select high the element is transparent and its output follows its source bus. With mode-select low it loads the source word on a high-to-low transition of its path strobe, and otherwise keeps its contents. Each path has its own output enable. The A-to-B enable is active high and the B-to-A enable is active low. Each bus is modelled as a separate input vector, output vector and per-bit output-enable vector, not as tri-state pins.

Every control and data input is registered through a short synchronizer chain into the system clock domain. Everything therefore reaches the outputs after one fixed latency. A build-time switch adds bus-hold emulation. When a side's driver-valid flag is low, that path uses the last word seen while the flag was high. A contention flag reports cycles in which both buses are driven.

Top module: `bus_xcvr`

## Requirements
- R1: A synchronous reset clears both stored words, their held bus-hold values and the contention flag to zero, and disables both output-enable vectors.
- R2: Every input change reaches the outputs exactly SYNC_STAGES+1 system clock cycles later (3 cycles with defaults). The output does not change one cycle earlier.
- R3: While the A-to-B mode-select `ab_pass` is high, `b_out` follows `a_in` unchanged, whatever the A-to-B strobe does.
- R4: While `ab_pass` is low, a synchronized A-to-B strobe sample of 1 followed by a sample of 0 loads the A word present in the sample where the strobe was 0.
- R5: While `ab_pass` is low and the A-to-B strobe holds steady or rises, `b_out` keeps its value.
- R6: `ab_drive` high sets every bit of `b_oe` to 1, and low clears every bit. Storage keeps updating while the outputs are disabled, so a word captured then appears once the enable returns.
- R7: The B-to-A path behaves like R3 to R5 with `ba_pass`, `ba_strobe`, `b_in` and `a_out`. Its enable `ba_drive_n` is active low: 0 sets all bits of `a_oe`, 1 clears them.
- R8: With HOLD_EN=1, a low driver-valid flag on a side makes that path use the last word sampled while the flag was high (zero after reset).
- R9: `contention` is 1 exactly when `b_oe` and `a_oe` are both enabled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Word seen on bus A |
| a_valid | input | 1 | An external driver is active on bus A |
| b_in | input | WIDTH | Word seen on bus B |
| b_valid | input | 1 | An external driver is active on bus B |
| ab_pass | input | 1 | A-to-B mode select: 1 transparent, 0 strobe-loaded |
| ab_strobe | input | 1 | A-to-B load strobe, acts on its falling edge |
| ab_drive | input | 1 | A-to-B output enable, active high |
| ba_pass | input | 1 | B-to-A mode select |
| ba_strobe | input | 1 | B-to-A load strobe |
| ba_drive_n | input | 1 | B-to-A output enable, active low |
| b_out | output | WIDTH | Word driven toward bus B |
| b_oe | output | WIDTH | Per-bit drive enable for bus B |
| a_out | output | WIDTH | Word driven toward bus A |
| a_oe | output | WIDTH | Per-bit drive enable for bus A |
| contention | output | 1 | Both buses are being driven |

## Verification
The hardest case to reach is a strobe falling edge in the same sample in which the driver-valid flag drops. In that case the element must load the held word, not the floating bus value. Random stimulus reaches it by toggling strobes and valid flags independently every cycle for thousands of cycles. A bench model running in parallel predicts every output. Directed sequences cover the latency boundary, a rising edge in strobe mode, loading while the outputs are disabled, and enable polarity.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    typedef enum logic [1:0] {
        ST_KEEP = 2'd0,
        ST_PASS = 2'd1,
        ST_EDGE = 2'd2
    } store_mode_e;

    function automatic store_mode_e pick_mode(input logic pass, input logic prev, input logic now);
        if (pass)
            return ST_PASS;
        else if (prev && !now)
            return ST_EDGE;
        else
            return ST_KEEP;
    endfunction
endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++)
            chain_d[i] = chain_q[i-1];
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++)
            chain_q[i] <= rst ? RST_VAL : chain_d[i];
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int WIDTH   = 18,
    parameter bit HOLD_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] src,
    input  logic             src_valid,
    input  logic             pass,
    input  logic             strobe,
    input  logic             drive,
    output logic [WIDTH-1:0] dst,
    output logic [WIDTH-1:0] dst_oe,
    output logic             upd
);
    typedef struct packed {
        logic [WIDTH-1:0] held;
        logic [WIDTH-1:0] stored;
        logic             strobe_prev;
        logic             drive;
    } path_t;

    path_t       st_q, st_d;
    logic [WIDTH-1:0] eff;
    store_mode_e mode;

    generate
        if (HOLD_EN) begin : g_hold
            assign eff = src_valid ? src : st_q.held;
        end else begin : g_nohold
            assign eff = src;
        end
    endgenerate

    always_comb begin
        st_d             = st_q;
        mode             = pick_mode(pass, st_q.strobe_prev, strobe);
        st_d.strobe_prev = strobe;
        st_d.drive       = drive;
        if (src_valid)
            st_d.held = src;
        if (mode != ST_KEEP)
            st_d.stored = eff;
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign upd    = (mode != ST_KEEP);
    assign dst    = st_q.stored;
    assign dst_oe = {WIDTH{st_q.drive}};
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
    parameter int WIDTH       = 18,
    parameter int SYNC_STAGES = 2,
    parameter bit HOLD_EN     = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic             a_valid,
    input  logic [WIDTH-1:0] b_in,
    input  logic             b_valid,
    input  logic             ab_pass,
    input  logic             ab_strobe,
    input  logic             ab_drive,
    input  logic             ba_pass,
    input  logic             ba_strobe,
    input  logic             ba_drive_n,
    output logic [WIDTH-1:0] b_out,
    output logic [WIDTH-1:0] b_oe,
    output logic [WIDTH-1:0] a_out,
    output logic [WIDTH-1:0] a_oe,
    output logic             contention
);
    localparam int SIDE_W = WIDTH + 4;

    logic [SIDE_W-1:0] a_side_s, b_side_s;
    logic [WIDTH-1:0]  a_s, b_s;
    logic              a_valid_s, b_valid_s;
    logic              ab_pass_s, ab_strobe_s, ab_drive_s;
    logic              ba_pass_s, ba_strobe_s, ba_drive_n_s;
    logic              ab_upd, ba_upd;

    typedef struct packed {
        logic contention;
    } top_t;

    top_t top_q, top_d;

    xcvr_sync #(.W(SIDE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_a (
        .clk  (clk),
        .rst  (rst),
        .din  ({a_in, a_valid, ab_pass, ab_strobe, ab_drive}),
        .dout (a_side_s)
    );

    xcvr_sync #(.W(SIDE_W), .STAGES(SYNC_STAGES), .RST_VAL(SIDE_W'(1))) u_sync_b (
        .clk  (clk),
        .rst  (rst),
        .din  ({b_in, b_valid, ba_pass, ba_strobe, ba_drive_n}),
        .dout (b_side_s)
    );

    assign {a_s, a_valid_s, ab_pass_s, ab_strobe_s, ab_drive_s}   = a_side_s;
    assign {b_s, b_valid_s, ba_pass_s, ba_strobe_s, ba_drive_n_s} = b_side_s;

    xcvr_path #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) u_ab (
        .clk       (clk),
        .rst       (rst),
        .src       (a_s),
        .src_valid (a_valid_s),
        .pass      (ab_pass_s),
        .strobe    (ab_strobe_s),
        .drive     (ab_drive_s),
        .dst       (b_out),
        .dst_oe    (b_oe),
        .upd       (ab_upd)
    );

    xcvr_path #(.WIDTH(WIDTH), .HOLD_EN(HOLD_EN)) u_ba (
        .clk       (clk),
        .rst       (rst),
        .src       (b_s),
        .src_valid (b_valid_s),
        .pass      (ba_pass_s),
        .strobe    (ba_strobe_s),
        .drive     (!ba_drive_n_s),
        .dst       (a_out),
        .dst_oe    (a_oe),
        .upd       (ba_upd)
    );

    always_comb begin
        top_d            = top_q;
        top_d.contention = ab_drive_s && !ba_drive_n_s;
    end

    always_ff @(posedge clk) begin
        if (rst)
            top_q <= '0;
        else
            top_q <= top_d;
    end

    assign contention = top_q.contention;
endmodule

// File: rtl/bus_xcvr_checker.sv
module bus_xcvr_checker #(
    parameter int WIDTH = 18
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] b_out,
    input logic [WIDTH-1:0] b_oe,
    input logic [WIDTH-1:0] a_out,
    input logic [WIDTH-1:0] a_oe,
    input logic             contention,
    input logic             ab_upd,
    input logic             ba_upd
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(rst) |-> (b_out == '0 && a_out == '0 && b_oe == '0 && a_oe == '0 && !contention));

    assert_ab_keep_R5: assert property (@(posedge clk) disable iff (rst)
        !ab_upd |=> $stable(b_out));

    assert_ba_keep_R7: assert property (@(posedge clk) disable iff (rst)
        !ba_upd |=> $stable(a_out));

    assert_b_oe_uniform_R6: assert property (@(posedge clk) disable iff (rst)
        (b_oe == '0 || b_oe == '1));

    assert_a_oe_uniform_R7: assert property (@(posedge clk) disable iff (rst)
        (a_oe == '0 || a_oe == '1));

    assert_contention_R9: assert property (@(posedge clk) disable iff (rst)
        contention == (b_oe[0] && a_oe[0]));
endmodule

bind bus_xcvr bus_xcvr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .b_out      (b_out),
    .b_oe       (b_oe),
    .a_out      (a_out),
    .a_oe       (a_oe),
    .contention (contention),
    .ab_upd     (ab_upd),
    .ba_upd     (ba_upd)
);

// File: tb/bus_xcvr_test.sv
module bus_xcvr_test;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         a_valid = 1'b1, b_valid = 1'b1;
    logic         ab_pass = 1'b0, ab_strobe = 1'b0, ab_drive = 1'b0;
    logic         ba_pass = 1'b0, ba_strobe = 1'b0, ba_drive_n = 1'b1;
    logic [W-1:0] b_out, b_oe, a_out, a_oe;
    logic         contention;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    bus_xcvr uut (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_valid(a_valid), .b_in(b_in), .b_valid(b_valid),
        .ab_pass(ab_pass), .ab_strobe(ab_strobe), .ab_drive(ab_drive),
        .ba_pass(ba_pass), .ba_strobe(ba_strobe), .ba_drive_n(ba_drive_n),
        .b_out(b_out), .b_oe(b_oe), .a_out(a_out), .a_oe(a_oe),
        .contention(contention)
    );

    // Reference model: two input sample stages, then storage as required.
    typedef struct packed {
        logic [W-1:0] d; logic v; logic pass; logic stb; logic en;
    } side_t;
    side_t ma1, ma2, mb1, mb2;
    logic [W-1:0] m_held_a, m_held_b, m_b_out, m_a_out;
    logic m_prev_a, m_prev_b, m_b_en, m_a_en, m_cont;

    function automatic logic [W-1:0] eff(input side_t s, input logic [W-1:0] held);
        return s.v ? s.d : held;
    endfunction

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            ma1 <= '0; ma2 <= '0;
            mb1 <= side_t'(1); mb2 <= side_t'(1);
            m_held_a <= '0; m_held_b <= '0; m_b_out <= '0; m_a_out <= '0;
            m_prev_a <= 1'b0; m_prev_b <= 1'b0;
            m_b_en <= 1'b0; m_a_en <= 1'b0; m_cont <= 1'b0;
        end else begin
            ma1 <= '{a_in, a_valid, ab_pass, ab_strobe, ab_drive};
            mb1 <= '{b_in, b_valid, ba_pass, ba_strobe, ba_drive_n};
            ma2 <= ma1; mb2 <= mb1;
            if (ma2.v) m_held_a <= ma2.d;
            if (mb2.v) m_held_b <= mb2.d;
            if (ma2.pass || (m_prev_a && !ma2.stb)) m_b_out <= eff(ma2, m_held_a);
            if (mb2.pass || (m_prev_b && !mb2.stb)) m_a_out <= eff(mb2, m_held_b);
            m_prev_a <= ma2.stb; m_prev_b <= mb2.stb;
            m_b_en <= ma2.en; m_a_en <= !mb2.en;
            m_cont <= ma2.en && !mb2.en;
        end
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 b_out reset", b_out, '0);
        check("R1 a_out reset", a_out, '0);
        check("R1 b_oe reset", b_oe, '0);
        check("R1 a_oe reset", a_oe, '0);
        check("R1 contention reset", W'(contention), '0);

        // R3 transparent path, R2 latency boundary
        ab_pass = 1'b1; ab_drive = 1'b1; a_in = 18'h2A5A5;
        step(2);
        check("R2 not yet at 2 cycles", b_out, '0);
        step(1);
        check("R3 transparent follow", b_out, 18'h2A5A5);
        check("R6 b_oe driven", b_oe, '1);
        ab_strobe = 1'b1; step(1); ab_strobe = 1'b0; a_in = 18'h11111; step(3);
        check("R3 follows despite strobe", b_out, 18'h11111);

        // R5 hold in strobe mode through a rising edge
        ab_pass = 1'b0; step(3);
        a_in = 18'h0F0F0; ab_strobe = 1'b1; step(4);
        check("R5 rising edge keeps value", b_out, 18'h11111);
        // R4 falling edge load
        a_in = 18'h3C3C3; ab_strobe = 1'b0; step(3);
        check("R4 falling edge load", b_out, 18'h3C3C3);

        // R6 storage updates while disabled
        ab_drive = 1'b0; ab_pass = 1'b1; a_in = 18'h12345; step(3);
        check("R6 b_oe released", b_oe, '0);
        ab_pass = 1'b0; a_in = 18'h00000; ab_drive = 1'b1; step(3);
        check("R6 captured word after enable", b_out, 18'h12345);

        // R7 B-to-A with active-low enable
        ba_pass = 1'b1; ba_drive_n = 1'b0; b_in = 18'h35AC1; step(3);
        check("R7 a_out follows", a_out, 18'h35AC1);
        check("R7 a_oe active low", a_oe, '1);
        check("R9 contention both driven", W'(contention), 18'h1);
        ba_drive_n = 1'b1; step(3);
        check("R7 a_oe released", a_oe, '0);
        check("R9 contention cleared", W'(contention), '0);

        // R8 bus-hold substitution
        ab_pass = 1'b1; a_valid = 1'b1; a_in = 18'h2BEEF; step(1);
        a_valid = 1'b0; a_in = 18'h00ACE; step(3);
        check("R8 held word used", b_out, 18'h2BEEF);
        a_valid = 1'b1; step(3);

        // Random phase against the bench model
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            check("R3 R4 R5 R8 b_out model", b_out, m_b_out);
            check("R7 a_out model", a_out, m_a_out);
            check("R6 b_oe model", b_oe, {W{m_b_en}});
            check("R7 a_oe model", a_oe, {W{m_a_en}});
            check("R9 contention model", W'(contention), W'(m_cont));
            a_in = W'($urandom); b_in = W'($urandom);
            a_valid = ($urandom % 4) != 0; b_valid = ($urandom % 4) != 0;
            ab_pass = ($urandom % 5) == 0; ba_pass = ($urandom % 5) == 0;
            ab_strobe = $urandom; ba_strobe = $urandom;
            ab_drive = $urandom; ba_drive_n = $urandom;
            step(1);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait (cycles >= 100000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule